// File: doc/BRIEF.md
# Transmit Descriptor Chain Engine

This block sends a chain of memory buffers to a peripheral one byte at a time. Each buffer is described by a three-word descriptor in memory. Word 0 holds the owner bit (bit 31, 1 = hardware may use it), the end-of-frame bit (bit 30), the valid byte count (bits 23:12) and the buffer capacity (bits 11:0, carried but not used). Word 1 (offset 4) holds the word-aligned buffer address. Word 2 (offset 8) holds the address of the next descriptor, and zero ends the chain. After a start pulse the engine reads the descriptors one after another. It fetches each buffer a 32-bit word at a time and sends the bytes least significant first into a 16-byte FIFO. The FIFO feeds the byte stream output.

The memory port uses a request/acknowledge pair. The engine holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack` is seen. On a read, `mem_rdata` is valid in the acknowledge cycle. The byte stream uses valid/ready. A byte is transferred in any cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the byte and `tx_last` stay unchanged. Back-pressure fills the FIFO, and when the FIFO is full the engine stops reading buffer data from memory. The engine waits until every byte of a descriptor has been delivered before it writes back that descriptor or reads the next one.

The event outputs are single-cycle pulses, each one cycle after its cause:
- a per-descriptor delivered event;
- an end-of-frame event, whose timing is set by a mode input;
- a chain-complete event;
- a descriptor error event.

The status outputs give the idle (park) state, the current descriptor address and the address of the last end-of-frame descriptor delivered.

Top module: `txd_chain_top`

## Requirements
- R1: After reset `st_park` is 1, `tx_valid`, `mem_req` and all events are 0, and the FIFO is empty. A `ctl_start` pulse while parked makes the first memory read at `ctl_start_addr`, and `st_park` stays 0 until the engine goes idle again.
- R2: Each descriptor delivers exactly its byte count (word 0 bits 23:12, from 1 upward), in address order. The bytes come from the buffer at word 1, least significant byte of each word first.
- R3: `tx_last` is 1 only on the final byte of a descriptor whose end-of-frame bit (word 0 bit 30) is set.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, and no stop is pulsed, `tx_valid`, `tx_data` and `tx_last` stay unchanged in the next cycle.
- R5: `ev_done` pulses one cycle after the final byte of each descriptor is accepted.
- R6: For an end-of-frame descriptor:
  - With `ctl_eof_mode` = 0, `ev_eof` pulses one cycle after the memory acknowledge of the word that holds its final byte.
  - With `ctl_eof_mode` = 1, `ev_eof` pulses one cycle after its final byte leaves the FIFO.
  - In both modes `st_eof_dscr` then shows that descriptor's address.
- R7: `ev_total_eof` pulses together with `ev_done` for the descriptor whose next pointer is zero. The engine then parks, unless a write-back is still pending.
- R8: With `ctl_auto_wb` = 1, after a descriptor's final byte is accepted the engine writes word 0 back to the descriptor address with bit 31 cleared and every other bit unchanged. It does this before it reads the next descriptor.
- R9: With `ctl_owner_chk` = 1, a word 0 whose bit 31 is 0 causes an `ev_dscr_err` pulse, the engine parks, and no bytes are sent. With `ctl_owner_chk` = 0 the same descriptor is processed normally.
- R10: A `ctl_stop` pulse parks the engine and empties the FIFO in the next cycle. After that, no memory request and no stream byte appear until a new start or restart.
- R11: A `ctl_restart` pulse while parked reads the next-pointer word (offset 8) of the current descriptor. If that word is nonzero the chain continues from there. If it is zero the engine parks again and sends nothing.
- R12: The FIFO holds 16 bytes and reports its count, full and empty. Under back-pressure it fills to 16, and nothing is pushed while it is full.
- R13: A memory request that has not yet been acknowledged keeps its address and direction in the next cycle, unless a stop is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_start | input | 1 | Start pulse: begin the chain at `ctl_start_addr` |
| ctl_stop | input | 1 | Stop pulse: abandon work and park |
| ctl_restart | input | 1 | Restart pulse: follow the current descriptor's next pointer |
| ctl_owner_chk | input | 1 | Enable the owner-bit check |
| ctl_auto_wb | input | 1 | Enable descriptor write-back |
| ctl_eof_mode | input | 1 | End-of-frame timing: 0 = memory read, 1 = FIFO pop |
| ctl_start_addr | input | AW | First descriptor address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | DW | Read data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of an end-of-frame descriptor |
| tx_ready | input | 1 | Peripheral accepts a byte |
| st_park | output | 1 | Engine idle |
| st_cur_dscr | output | AW | Current descriptor address |
| st_eof_dscr | output | AW | Last end-of-frame descriptor delivered |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| fifo_count | output | FCW | FIFO byte count |
| ev_done | output | 1 | Descriptor delivered pulse |
| ev_eof | output | 1 | End-of-frame pulse |
| ev_total_eof | output | 1 | Chain complete pulse |
| ev_dscr_err | output | 1 | Owner error pulse |

## Verification
The cycle that accepts the final byte of the final end-of-frame descriptor triggers three pulses together in the next cycle: descriptor delivered, chain complete and, in mode 1, end-of-frame. The engine also parks in that same cycle. The chained runs end on such a descriptor. The bench records the cycle of every accepted byte and every pulse, and it requires all of these pulses exactly one cycle after that byte. A second overlap is back-pressure that stalls the FIFO while a buffer read is still waiting for its acknowledge. This is provoked by holding `tx_ready` low over a long buffer, and it is judged by the FIFO reaching 16 bytes while the delivered stream stays exact.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int unsigned OWN_BIT  = 31;
  localparam int unsigned EOF_BIT  = 30;
  localparam int unsigned LEN_LSB  = 12;
  localparam int unsigned LEN_W    = 12;
  localparam int unsigned OFS_BUF  = 4;
  localparam int unsigned OFS_NEXT = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_W0, S_W1, S_W2, S_BUF, S_DRAIN, S_WB, S_NXT
  } walk_state_e;
endpackage

// File: rtl/txd_byte_fifo.sv
module txd_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign pop_data = store[rp];
  assign count    = cnt;
  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);

  p_no_push_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_pop_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/txd_walker.sv
module txd_walker import txd_pkg::*; #(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_start,
  input  logic          ctl_stop,
  input  logic          ctl_restart,
  input  logic          ctl_owner_chk,
  input  logic          ctl_auto_wb,
  input  logic          ctl_eof_mode,
  input  logic [AW-1:0] ctl_start_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          fifo_full,
  output logic          push,
  output logic [7:0]    push_data,
  input  logic          pop_fire,
  output logic          tx_last,
  output logic          flush,
  output logic          st_park,
  output logic [AW-1:0] st_cur_dscr,
  output logic [AW-1:0] st_eof_dscr,
  output logic          ev_done,
  output logic          ev_eof,
  output logic          ev_total_eof,
  output logic          ev_dscr_err
);
  localparam int BPW = DW / 8;
  localparam int HW  = $clog2(BPW + 1);

  walk_state_e      st;
  logic [AW-1:0]    cur, nxt, rd_ptr, eof_addr;
  logic [DW-1:0]    w0, hold;
  logic [HW-1:0]    hold_cnt, chunk;
  logic [LEN_W-1:0] bytes_left, pop_left, rd_len;
  logic             ack, fin, is_eof;

  assign rd_len = mem_rdata[LEN_LSB +: LEN_W];
  assign is_eof = w0[EOF_BIT];
  assign ack    = mem_req && mem_ack;
  assign chunk  = (bytes_left > LEN_W'(BPW)) ? HW'(BPW) : bytes_left[HW-1:0];
  assign fin    = (st == S_DRAIN) &&
                  ((pop_left == '0) || (pop_fire && pop_left == LEN_W'(1)));

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur;
    unique case (st)
      S_W0:         mem_req = 1'b1;
      S_W1: begin
        mem_req  = 1'b1;
        mem_addr = cur + AW'(OFS_BUF);
      end
      S_W2, S_NXT: begin
        mem_req  = 1'b1;
        mem_addr = cur + AW'(OFS_NEXT);
      end
      S_BUF: begin
        mem_req  = (hold_cnt == '0) && (bytes_left != '0);
        mem_addr = rd_ptr;
      end
      S_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_wdata = w0 & ~(DW'(1) << OWN_BIT);
  assign push      = (hold_cnt != '0) && !fifo_full;
  assign push_data = hold[7:0];
  assign tx_last   = is_eof && (pop_left == LEN_W'(1));
  assign flush     = ctl_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cur          <= '0;
      nxt          <= '0;
      rd_ptr       <= '0;
      eof_addr     <= '0;
      w0           <= '0;
      hold         <= '0;
      hold_cnt     <= '0;
      bytes_left   <= '0;
      pop_left     <= '0;
      ev_done      <= 1'b0;
      ev_eof       <= 1'b0;
      ev_total_eof <= 1'b0;
      ev_dscr_err  <= 1'b0;
    end else begin
      ev_done      <= 1'b0;
      ev_eof       <= 1'b0;
      ev_total_eof <= 1'b0;
      ev_dscr_err  <= 1'b0;
      if (ctl_stop) begin
        st         <= S_IDLE;
        hold_cnt   <= '0;
        bytes_left <= '0;
        pop_left   <= '0;
      end else begin
        if (push) begin
          hold     <= hold >> 8;
          hold_cnt <= hold_cnt - 1'b1;
        end
        if (pop_fire && pop_left != '0) pop_left <= pop_left - 1'b1;
        unique case (st)
          S_IDLE: begin
            if (ctl_start) begin
              cur <= ctl_start_addr;
              st  <= S_W0;
            end else if (ctl_restart) begin
              st <= S_NXT;
            end
          end
          S_W0: if (ack) begin
            if (ctl_owner_chk && !mem_rdata[OWN_BIT]) begin
              ev_dscr_err <= 1'b1;
              st          <= S_IDLE;
            end else begin
              w0         <= mem_rdata;
              bytes_left <= rd_len;
              pop_left   <= rd_len;
              st         <= S_W1;
            end
          end
          S_W1: if (ack) begin
            rd_ptr <= mem_rdata[AW-1:0] & ~AW'(BPW - 1);
            st     <= S_W2;
          end
          S_W2: if (ack) begin
            nxt <= mem_rdata[AW-1:0];
            st  <= (bytes_left == '0) ? S_DRAIN : S_BUF;
          end
          S_BUF: if (ack) begin
            hold       <= mem_rdata;
            hold_cnt   <= chunk;
            bytes_left <= bytes_left - LEN_W'(chunk);
            rd_ptr     <= rd_ptr + AW'(BPW);
            if (bytes_left <= LEN_W'(BPW)) begin
              st <= S_DRAIN;
              if (is_eof && !ctl_eof_mode) ev_eof <= 1'b1;
            end
          end
          S_DRAIN: if (fin) begin
            ev_done <= 1'b1;
            if (is_eof) begin
              eof_addr <= cur;
              if (ctl_eof_mode) ev_eof <= 1'b1;
            end
            if (nxt == '0) ev_total_eof <= 1'b1;
            if (ctl_auto_wb) st <= S_WB;
            else if (nxt == '0) st <= S_IDLE;
            else begin
              cur <= nxt;
              st  <= S_W0;
            end
          end
          S_WB: if (ack) begin
            if (nxt == '0) st <= S_IDLE;
            else begin
              cur <= nxt;
              st  <= S_W0;
            end
          end
          S_NXT: if (ack) begin
            if (mem_rdata[AW-1:0] == '0) st <= S_IDLE;
            else begin
              cur <= mem_rdata[AW-1:0];
              st  <= S_W0;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign st_park     = (st == S_IDLE);
  assign st_cur_dscr = cur;
  assign st_eof_dscr = eof_addr;

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !ctl_stop) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_err_parks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dscr_err |-> (st_park && !ev_done));
  p_total_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_total_eof |-> ev_done);
endmodule

// File: rtl/txd_chain_top.sv
module txd_chain_top #(
  parameter int AW         = 20,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 16,
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_start,
  input  logic           ctl_stop,
  input  logic           ctl_restart,
  input  logic           ctl_owner_chk,
  input  logic           ctl_auto_wb,
  input  logic           ctl_eof_mode,
  input  logic [AW-1:0]  ctl_start_addr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic [7:0]     tx_data,
  output logic           tx_valid,
  output logic           tx_last,
  input  logic           tx_ready,
  output logic           st_park,
  output logic [AW-1:0]  st_cur_dscr,
  output logic [AW-1:0]  st_eof_dscr,
  output logic           fifo_full,
  output logic           fifo_empty,
  output logic [FCW-1:0] fifo_count,
  output logic           ev_done,
  output logic           ev_eof,
  output logic           ev_total_eof,
  output logic           ev_dscr_err
);
  logic       push, pop_fire, flush;
  logic [7:0] push_data;

  assign tx_valid = !fifo_empty;
  assign pop_fire = tx_valid && tx_ready;

  txd_walker #(.AW(AW), .DW(DW)) u_walker (
    .clk, .rst_n, .ctl_start, .ctl_stop, .ctl_restart, .ctl_owner_chk,
    .ctl_auto_wb, .ctl_eof_mode, .ctl_start_addr,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .fifo_full, .push, .push_data, .pop_fire, .tx_last, .flush,
    .st_park, .st_cur_dscr, .st_eof_dscr,
    .ev_done, .ev_eof, .ev_total_eof, .ev_dscr_err
  );

  txd_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk, .rst_n, .flush, .push, .push_data, .pop(pop_fire),
    .pop_data(tx_data), .full(fifo_full), .empty(fifo_empty), .count(fifo_count)
  );

  p_tx_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !ctl_stop) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_last)));
  p_stop_parks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stop |=> (st_park && fifo_empty));
endmodule

// File: tb/txd_chain_top_tb.sv
`timescale 1ns/1ps
module txd_chain_top_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_start = 0, ctl_stop = 0, ctl_restart = 0;
  logic ctl_owner_chk = 1, ctl_auto_wb = 0, ctl_eof_mode = 0;
  logic [19:0] ctl_start_addr = '0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [19:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, tx_ready = 0;
  logic st_park, fifo_full, fifo_empty;
  logic [19:0] st_cur_dscr, st_eof_dscr;
  logic [4:0] fifo_count;
  logic ev_done, ev_eof, ev_total_eof, ev_dscr_err;

  txd_chain_top u_dut (.*);

  always #2.5 clk = ~clk;

  logic [31:0] mem [1024];
  always_comb mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ack_pct = 70, rdy_pct = 60;
  int r4_bad = 0, r13_bad = 0, err_n = 0;
  int pop_c[$], done_c[$], eof_c[$], tot_c[$], rd_a[$], rd_c[$], wr_a[$];
  logic [31:0] wr_d[$];
  logic [7:0] got_b[$], exp_b[$];
  bit got_l[$], exp_l[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "WATCHDOG", "run hung", cyc, 150000);
      finish_run();
    end
  end

  always @(posedge clk) begin
    #1;
    mem_ack  = ($urandom % 100) < ack_pct;
    tx_ready = ($urandom % 100) < rdy_pct;
  end

  bit p_vnr = 0, p_stop = 0, p_rw = 0, p_we = 0, p_l = 0;
  logic [7:0] p_d;
  logic [19:0] p_a;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_vnr && !p_stop && (!tx_valid || tx_data != p_d || tx_last != p_l)) r4_bad++;
      if (p_rw && !p_stop && (!mem_req || mem_addr != p_a || mem_we != p_we)) r13_bad++;
      p_vnr = tx_valid && !tx_ready; p_d = tx_data; p_l = tx_last;
      p_rw = mem_req && !mem_ack; p_a = mem_addr; p_we = mem_we; p_stop = ctl_stop;
      if (tx_valid && tx_ready) begin
        got_b.push_back(tx_data); got_l.push_back(tx_last); pop_c.push_back(cyc);
      end
      if (ev_done) done_c.push_back(cyc);
      if (ev_eof) eof_c.push_back(cyc);
      if (ev_total_eof) tot_c.push_back(cyc);
      if (ev_dscr_err) err_n++;
      if (mem_req && mem_ack) begin
        if (mem_we) begin wr_a.push_back(mem_addr); wr_d.push_back(mem_wdata); end
        else begin rd_a.push_back(mem_addr); rd_c.push_back(cyc); end
      end
    end
  end

  task automatic clear_logs();
    pop_c.delete(); done_c.delete(); eof_c.delete(); tot_c.delete();
    rd_a.delete(); rd_c.delete(); wr_a.delete(); wr_d.delete();
    got_b.delete(); got_l.delete(); exp_b.delete(); exp_l.delete(); err_n = 0;
  endtask

  function automatic logic [31:0] w0_of(input bit own, input bit eof, input int len);
    return {own, eof, 6'b0, 12'(len), 12'd64};
  endfunction

  task automatic mk_desc(input int a, input bit own, input bit eof, input int len,
                         input int bufa, input int nxt);
    mem[a >> 2] = w0_of(own, eof, len);
    mem[(a >> 2) + 1] = 32'(bufa);
    mem[(a >> 2) + 2] = 32'(nxt);
    for (int w = 0; w < (len + 3) / 4; w++) mem[(bufa >> 2) + w] = $urandom;
  endtask

  task automatic add_exp(input int bufa, input int len, input bit eof);
    for (int i = 0; i < len; i++) begin
      exp_b.push_back(mem[(bufa + i) >> 2][8 * ((bufa + i) % 4) +: 8]);
      exp_l.push_back(eof && (i == len - 1));
    end
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    if (which == 0) ctl_start = 1; else if (which == 1) ctl_restart = 1; else ctl_stop = 1;
    @(posedge clk); #1;
    ctl_start = 0; ctl_restart = 0; ctl_stop = 0;
  endtask

  task automatic wait_park();
    int t = 0;
    while (!st_park && t < 20000) begin @(negedge clk); t++; end
    check(st_park, "R1", "park after run", st_park, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    int bad = -1, bl = -1;
    check(got_b.size() == exp_b.size(), req, "byte count", got_b.size(), exp_b.size());
    if (got_b.size() == exp_b.size()) begin
      for (int i = 0; i < got_b.size(); i++) begin
        if (bad < 0 && got_b[i] != exp_b[i]) bad = i;
        if (bl < 0 && got_l[i] != exp_l[i]) bl = i;
      end
      check(bad < 0, req, "byte value", bad < 0 ? 0 : got_b[bad], bad < 0 ? 0 : exp_b[bad]);
      check(bl < 0, "R3", "last flag position", bl, -1);
    end
  endtask

  task automatic chk_done(input int lens[$]);
    int cum = 0;
    check(done_c.size() == lens.size(), "R5", "done count", done_c.size(), lens.size());
    for (int k = 0; k < lens.size() && k < done_c.size(); k++) begin
      cum += lens[k];
      if (cum <= pop_c.size())
        check(done_c[k] == pop_c[cum - 1] + 1, "R5", "done timing", done_c[k], pop_c[cum - 1] + 1);
    end
  endtask

  function automatic int rd_cycle(input int addr);
    foreach (rd_a[i]) if (rd_a[i] == addr) return rd_c[i];
    return -100;
  endfunction

  initial begin
    int l0, l1, l2, l3, cum;
    int lens[$];
    void'($urandom(32'h1d5a7));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(st_park == 1 && tx_valid == 0 && mem_req == 0, "R1", "reset park/valid/req",
          {st_park, tx_valid, mem_req}, 3'b100);
    check(fifo_empty && fifo_count == 0 && !fifo_full, "R12", "reset fifo", fifo_count, 0);
    check({ev_done, ev_eof, ev_total_eof, ev_dscr_err} == 0, "R1", "reset events",
          {ev_done, ev_eof, ev_total_eof, ev_dscr_err}, 0);

    // T1: three-descriptor chain, eof mode 0
    l0 = $urandom_range(1, 40); l1 = $urandom_range(1, 40); l2 = $urandom_range(1, 40);
    mk_desc(32'h100, 1, 0, l0, 32'h400, 32'h110);
    mk_desc(32'h110, 1, 0, l1, 32'h500, 32'h120);
    mk_desc(32'h120, 1, 1, l2, 32'h600, 0);
    clear_logs();
    add_exp(32'h400, l0, 0); add_exp(32'h500, l1, 0); add_exp(32'h600, l2, 1);
    ctl_start_addr = 20'h100; ctl_eof_mode = 0; ctl_auto_wb = 0;
    pulse(0);
    check(!st_park, "R1", "busy after start", st_park, 0);
    wait_park();
    check(rd_a.size() > 0 && rd_a[0] == 32'h100, "R1", "first read address", rd_a.size() > 0 ? rd_a[0] : -1, 32'h100);
    cmp_stream("R2");
    lens = '{l0, l1, l2};
    chk_done(lens);
    check(eof_c.size() == 1 && eof_c[0] == rd_cycle(32'h600 + ((l2 - 1) / 4) * 4) + 1, "R6",
          "mode0 eof timing", eof_c.size() > 0 ? eof_c[0] : -1, rd_cycle(32'h600 + ((l2 - 1) / 4) * 4) + 1);
    check(st_eof_dscr == 20'h120, "R6", "eof descriptor status", st_eof_dscr, 32'h120);
    check(tot_c.size() == 1 && done_c.size() == 3 && tot_c[0] == done_c[2], "R7", "total eof with last done",
          tot_c.size(), 1);
    check(wr_a.size() == 0, "R8", "no write-back when disabled", wr_a.size(), 0);

    // T5: restart follows appended next pointer
    l3 = $urandom_range(1, 30);
    mk_desc(32'h130, 1, 1, l3, 32'h700, 0);
    mem[(32'h120 >> 2) + 2] = 32'h130;
    clear_logs();
    add_exp(32'h700, l3, 1);
    pulse(1);
    wait_park();
    check(rd_a.size() > 0 && rd_a[0] == 32'h128, "R11", "restart reads next field", rd_a.size() > 0 ? rd_a[0] : -1, 32'h128);
    cmp_stream("R11");
    clear_logs();
    pulse(1);
    wait_park();
    check(rd_a.size() == 1 && rd_a[0] == 32'h138 && got_b.size() == 0, "R11", "restart at chain end parks",
          rd_a.size(), 1);

    // T2: back-pressure, mode 1, write-back
    l0 = $urandom_range(24, 40); l1 = $urandom_range(1, 30);
    mk_desc(32'h200, 1, 1, l0, 32'h800, 32'h210);
    mk_desc(32'h210, 1, 1, l1, 32'h900, 0);
    clear_logs();
    add_exp(32'h800, l0, 1); add_exp(32'h900, l1, 1);
    ctl_start_addr = 20'h200; ctl_eof_mode = 1; ctl_auto_wb = 1; rdy_pct = 0; ack_pct = 80;
    pulse(0);
    repeat (60) @(negedge clk);
    check(fifo_count == 16 && fifo_full && tx_valid, "R12", "fifo fills to 16", fifo_count, 16);
    check(mem_req == 0 || mem_we == 0, "R12", "no extra push while full", fifo_count, 16);
    rdy_pct = 50;
    wait_park();
    cmp_stream("R2");
    lens = '{l0, l1};
    chk_done(lens);
    check(wr_a.size() == 2 && wr_a[0] == 32'h200 && wr_a[1] == 32'h210, "R8", "write-back addresses",
          wr_a.size(), 2);
    if (wr_d.size() == 2) begin
      check(wr_d[0] == w0_of(0, 1, l0), "R8", "write-back data 0", wr_d[0], w0_of(0, 1, l0));
      check(wr_d[1] == w0_of(0, 1, l1), "R8", "write-back data 1", wr_d[1], w0_of(0, 1, l1));
      check(rd_cycle(32'h210) > 0 && wr_a[0] == 32'h200, "R8", "write-back before next fetch",
            rd_cycle(32'h210), 1);
    end
    check(eof_c.size() == 2 && done_c.size() == 2 && eof_c[0] == done_c[0] && eof_c[1] == done_c[1],
          "R6", "mode1 eof with final pop", eof_c.size(), 2);
    check(st_eof_dscr == 20'h210, "R6", "eof status mode1", st_eof_dscr, 32'h210);
    check(tot_c.size() == 1, "R7", "one total eof", tot_c.size(), 1);

    // T3: owner check
    ctl_auto_wb = 0; ctl_eof_mode = 0; rdy_pct = 70;
    mk_desc(32'h300, 0, 0, 5, 32'hA00, 0);
    clear_logs();
    ctl_start_addr = 20'h300; ctl_owner_chk = 1;
    pulse(0);
    wait_park();
    check(err_n == 1 && got_b.size() == 0, "R9", "owner error parks", err_n, 1);
    clear_logs();
    add_exp(32'hA00, 5, 0);
    ctl_owner_chk = 0;
    pulse(0);
    wait_park();
    check(err_n == 0, "R9", "no error with check off", err_n, 0);
    cmp_stream("R9");

    // T4: stop mid transfer
    mk_desc(32'h340, 1, 1, 120, 32'hB00, 0);
    clear_logs();
    ctl_start_addr = 20'h340; rdy_pct = 40;
    pulse(0);
    cum = 0;
    while (got_b.size() < 10 && cum < 5000) begin @(negedge clk); cum++; end
    pulse(2);
    @(negedge clk);
    check(st_park && fifo_empty && !tx_valid, "R10", "stop parks and flushes",
          {st_park, fifo_empty, tx_valid}, 3'b110);
    clear_logs();
    repeat (30) @(negedge clk);
    check(rd_a.size() == 0 && wr_a.size() == 0 && got_b.size() == 0, "R10", "quiet after stop",
          rd_a.size() + got_b.size(), 0);

    check(r4_bad == 0, "R4", "stream held under back-pressure", r4_bad, 0);
    check(r13_bad == 0, "R13", "memory request held until ack", r13_bad, 0);
    finish_run();
  end
endmodule